// File: doc/BRIEF.md
# Real-Time Clock Interrupt and Watchdog Controller

This block merges three interrupt causes of a real-time clock onto one shared, open-drain style request line, and it generates a CPU reset. The first cause is an alarm, raised when the current seconds, minutes and hours all equal programmed alarm values. The second is a periodic event, taken from one of fifteen prescaler taps chosen by a 4-bit rate code. The third is a power-fail sense input. Each cause has its own enable and its own sticky status flag. The request line is pulled low while any flag is set. A read strobe on the status register clears every flag and so releases the line.

The CPU reset output works only when its enable bit is set. When enabled, it asserts for as long as the power-fail input is high. It also asserts for a fixed number of clock cycles when a watchdog expires. The watchdog counts rising edges of one prescaler tap. It is restarted by a bare chip-enable pulse: chip-enable goes high and then low again with no serial transfer in progress at any point during that pulse. All inputs are taken to be synchronous to `clk`. Chip-enable is active high.

Top module: `rtc_irq_wdog`

## Requirements
- R1: After reset, `status` is 0, `irq_pulldown` is 0 and `cpu_rst` is 0 while `pwr_fail` is 0.
- R2: With `en_alarm` set, `status[0]` (the alarm flag) becomes 1 one cycle after the first cycle in which seconds, minutes and hours all equal the alarm values. The flag is raised only on entry into the match. A match that continues does not raise it again after a clear.
- R3: If any one of the three time fields differs from its alarm value, the alarm flag stays 0.
- R4: A rate code n from 1 to 15 selects tap n-1. A rising edge on that tap sets `status[1]` (the periodic flag) one cycle later. Edges on other taps have no effect.
- R5: Rate code 0 disables the periodic source, so no tap edge sets `status[1]`.
- R6: With `en_pfail` set, a rising edge of `pwr_fail` sets `status[2]` (the power-fail flag) one cycle later.
- R7: A source whose enable bit is 0 never sets its flag.
- R8: `irq_pulldown` is 1 exactly when at least one status flag is 1.
- R9: A one-cycle `stat_rd` clears all flags at the next clock edge. An event arriving in the same cycle as the read stays set.
- R10: While `cpur_en` is 1, `cpu_rst` follows `pwr_fail` high in the same cycle.
- R11: With `cpur_en` set, WDOG_TICKS rising edges of tap WDOG_TAP (default 4 edges of tap 7) with no valid kick assert `cpu_rst` for exactly RST_PULSE cycles (default 8). The pulse starts at the clock edge that samples the last tick.
- R12: A valid kick is `ce` high and then low, with `xfer_active` low in every cycle of that pulse. A valid kick restarts the tick count from zero.
- R13: A chip-enable pulse during which `xfer_active` was high does not restart the watchdog.
- R14: While `cpur_en` is 0, `cpu_rst` stays 0 and the watchdog count is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hr | input | 8 | Current hours, BCD |
| alm_sec | input | 8 | Alarm seconds, BCD |
| alm_min | input | 8 | Alarm minutes, BCD |
| alm_hr | input | 8 | Alarm hours, BCD |
| rate_sel | input | 4 | Periodic rate code, 0 = off |
| taps | input | 15 | Prescaler tap levels |
| pwr_fail | input | 1 | Power-fail sense, active high |
| ce | input | 1 | Chip-enable pin, active high |
| xfer_active | input | 1 | Serial transfer in progress |
| en_alarm | input | 1 | Alarm source enable |
| en_periodic | input | 1 | Periodic source enable |
| en_pfail | input | 1 | Power-fail source enable |
| cpur_en | input | 1 | CPU reset and watchdog enable |
| stat_rd | input | 1 | Status read strobe, clears flags |
| status | output | 3 | Flags: bit0 alarm, bit1 periodic, bit2 power-fail |
| irq_pulldown | output | 1 | 1 = pull the shared request line low |
| cpu_rst | output | 1 | CPU reset, active high |

## Verification
The timing differs by output. Flag results, and the release of the request line after a read, are due one clock edge after the stimulus. The bench therefore drives every input on a falling edge and samples after exactly one rising edge. The reset output from power-fail is combinational, so it is sampled one time step after the input changes. The watchdog pulse begins at the edge that takes the final tap edge. The bench counts the falling edges on which `cpu_rst` is high and requires the count to be exactly the pulse width, with the line low after that. Kicks with and without a transfer are placed between counted tap edges, so that whether the reset arrives shows whether the count was restarted.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
   localparam int SRC_ALARM = 0;
   localparam int SRC_PER   = 1;
   localparam int SRC_PF    = 2;
   localparam int NUM_SRC   = 3;
   typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
   parameter int TIME_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [TIME_W-1:0] cur_sec,
   input  logic [TIME_W-1:0] cur_min,
   input  logic [TIME_W-1:0] cur_hr,
   input  logic [TIME_W-1:0] alm_sec,
   input  logic [TIME_W-1:0] alm_min,
   input  logic [TIME_W-1:0] alm_hr,
   output logic              evt
);
   logic match, match_q;

   assign match = enable && (cur_sec == alm_sec) && (cur_min == alm_min) && (cur_hr == alm_hr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_q <= 1'b0;
      else        match_q <= match;
   end

   assign evt = match && !match_q;

   AST_ALARM_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n) evt |=> !evt); // R2
endmodule

// File: rtl/rtc_rate_select.sv
module rtc_rate_select #(
   parameter int RATE_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     enable,
   input  logic [RATE_W-1:0]        rate_sel,
   input  logic [(2**RATE_W)-2:0]   taps,
   output logic                     evt
);
   localparam int NUM_RATES = (2**RATE_W) - 1;

   logic [NUM_RATES-1:0] taps_q;
   logic [NUM_RATES:0]   rise_ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) taps_q <= '0;
      else        taps_q <= taps;
   end

   assign rise_ext[0] = 1'b0;
   for (genvar k = 0; k < NUM_RATES; k++) begin : g_tap_edge
      assign rise_ext[k+1] = taps[k] && !taps_q[k];
   end

   assign evt = enable && rise_ext[rate_sel];

   AST_RATE_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n) evt |-> rate_sel != '0); // R5
endmodule

// File: rtl/rtc_wdog.sv
module rtc_wdog #(
   parameter int WDOG_TICKS = 4,
   parameter int RST_PULSE  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic tick_tap,
   input  logic ce,
   input  logic xfer_active,
   output logic wd_active
);
   localparam int CNT_W = $clog2(WDOG_TICKS + 1);
   localparam int PW    = $clog2(RST_PULSE + 1);

   logic             tap_q, ce_q, dirty, tick, kick;
   logic [CNT_W-1:0] cnt;
   logic [PW-1:0]    pulse;

   assign tick = tick_tap && !tap_q;
   assign kick = ce_q && !ce && !dirty && !xfer_active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tap_q <= 1'b0;
         ce_q  <= 1'b0;
         dirty <= 1'b0;
      end else begin
         tap_q <= tick_tap;
         ce_q  <= ce;
         if (ce && !ce_q)  dirty <= xfer_active;
         else if (ce)      dirty <= dirty || xfer_active;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         pulse <= '0;
      end else if (!enable) begin
         cnt   <= '0;
         pulse <= '0;
      end else if (pulse != '0) begin
         pulse <= pulse - 1'b1;
         cnt   <= '0;
      end else if (kick) begin
         cnt <= '0;
      end else if (tick) begin
         if (cnt == CNT_W'(WDOG_TICKS - 1)) begin
            cnt   <= '0;
            pulse <= PW'(RST_PULSE);
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign wd_active = (pulse != '0);

   AST_WD_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n) !enable |=> !wd_active); // R14
   AST_WD_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n) $rose(wd_active) |-> $past(tick)); // R11
   AST_KICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (kick && enable && !wd_active) |=> cnt == '0); // R12
endmodule

// File: rtl/rtc_irq_wdog.sv
module rtc_irq_wdog
   import rtc_irq_pkg::*;
#(
   parameter int TIME_W     = 8,
   parameter int RATE_W     = 4,
   parameter int WDOG_TAP   = 7,
   parameter int WDOG_TICKS = 4,
   parameter int RST_PULSE  = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [TIME_W-1:0]      cur_sec,
   input  logic [TIME_W-1:0]      cur_min,
   input  logic [TIME_W-1:0]      cur_hr,
   input  logic [TIME_W-1:0]      alm_sec,
   input  logic [TIME_W-1:0]      alm_min,
   input  logic [TIME_W-1:0]      alm_hr,
   input  logic [RATE_W-1:0]      rate_sel,
   input  logic [(2**RATE_W)-2:0] taps,
   input  logic                   pwr_fail,
   input  logic                   ce,
   input  logic                   xfer_active,
   input  logic                   en_alarm,
   input  logic                   en_periodic,
   input  logic                   en_pfail,
   input  logic                   cpur_en,
   input  logic                   stat_rd,
   output logic [NUM_SRC-1:0]     status,
   output logic                   irq_pulldown,
   output logic                   cpu_rst
);
   localparam int NUM_RATES = (2**RATE_W) - 1;

   if (TIME_W != 8) begin : g_chk_time
      $error("TIME_W must be 8 for two BCD digits");
   end
   if (WDOG_TAP < 0 || WDOG_TAP >= NUM_RATES) begin : g_chk_tap
      $error("WDOG_TAP out of tap range");
   end
   if (WDOG_TICKS < 1 || RST_PULSE < 1) begin : g_chk_wd
      $error("watchdog counts must be positive");
   end

   src_vec_t evt, flags;
   logic     pf_q, wd_active;

   rtc_alarm_match #(.TIME_W(TIME_W)) u_alarm (
      .clk(clk), .rst_n(rst_n), .enable(en_alarm),
      .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
      .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
      .evt(evt[SRC_ALARM])
   );

   rtc_rate_select #(.RATE_W(RATE_W)) u_rate (
      .clk(clk), .rst_n(rst_n), .enable(en_periodic),
      .rate_sel(rate_sel), .taps(taps), .evt(evt[SRC_PER])
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pf_q <= 1'b0;
      else        pf_q <= pwr_fail;
   end
   assign evt[SRC_PF] = en_pfail && pwr_fail && !pf_q;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flags[s] <= 1'b0;
         else        flags[s] <= (flags[s] && !stat_rd) || evt[s];
      end
   end

   rtc_wdog #(.WDOG_TICKS(WDOG_TICKS), .RST_PULSE(RST_PULSE)) u_wdog (
      .clk(clk), .rst_n(rst_n), .enable(cpur_en),
      .tick_tap(taps[WDOG_TAP]), .ce(ce), .xfer_active(xfer_active),
      .wd_active(wd_active)
   );

   assign status       = flags;
   assign irq_pulldown = |flags;
   assign cpu_rst      = cpur_en && (pwr_fail || wd_active);

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (stat_rd && evt == '0) |=> status == '0); // R9
   AST_ALARM_GATED: assert property (@(posedge clk) disable iff (!rst_n) (!en_alarm && !status[SRC_ALARM]) |=> !status[SRC_ALARM]); // R7
   AST_PER_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rate_sel == '0 && !status[SRC_PER]) |=> !status[SRC_PER]); // R5
   AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) cpu_rst |-> cpur_en); // R14
   AST_PF_RESET: assert property (@(posedge clk) disable iff (!rst_n) (cpur_en && pwr_fail) |-> cpu_rst); // R10
endmodule

// File: tb/tb_rtc_irq_wdog.sv
module tb_rtc_irq_wdog;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cur_sec = '0, cur_min = '0, cur_hr = '0;
   logic [7:0]  alm_sec = 8'h59, alm_min = 8'h59, alm_hr = 8'h23;
   logic [3:0]  rate_sel = '0;
   logic [14:0] taps = '0;
   logic        pwr_fail = 1'b0, ce = 1'b0, xfer_active = 1'b0;
   logic        en_alarm = 1'b0, en_periodic = 1'b0, en_pfail = 1'b0, cpur_en = 1'b0;
   logic        stat_rd = 1'b0;
   logic [2:0]  status;
   logic        irq_pulldown, cpu_rst;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   rtc_irq_wdog dut (
      .clk(clk), .rst_n(rst_n),
      .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
      .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
      .rate_sel(rate_sel), .taps(taps), .pwr_fail(pwr_fail),
      .ce(ce), .xfer_active(xfer_active),
      .en_alarm(en_alarm), .en_periodic(en_periodic), .en_pfail(en_pfail),
      .cpur_en(cpur_en), .stat_rd(stat_rd),
      .status(status), .irq_pulldown(irq_pulldown), .cpu_rst(cpu_rst)
   );

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic read_clear();
      stat_rd = 1'b1; cyc(1); stat_rd = 1'b0;
   endtask

   task automatic pulse_tap(int idx);
      taps[idx] = 1'b1; cyc(1); taps[idx] = 1'b0; cyc(1);
   endtask

   task automatic ce_pulse(bit with_xfer);
      ce = 1'b1; cyc(1);
      xfer_active = with_xfer; cyc(1);
      xfer_active = 1'b0; ce = 1'b0; cyc(2);
   endtask

   task automatic t_reset();
      check("R1 status", status, 0);
      check("R1 irq", irq_pulldown, 0);
      check("R1 cpu_rst", cpu_rst, 0);
   endtask

   task automatic t_alarm();
      en_alarm = 1'b1;
      cur_sec = 8'h56; cur_min = 8'h34; cur_hr = 8'h12;
      alm_sec = 8'h56; alm_min = 8'h34; alm_hr = 8'h12;
      cyc(1);
      check("R2 alarm flag", status, 3'b001);
      check("R8 irq on flag", irq_pulldown, 1);
      read_clear();
      check("R9 read clears", status, 0);
      check("R8 irq released", irq_pulldown, 0);
      cyc(3);
      check("R2 held match no retrigger", status, 0);
   endtask

   task automatic t_alarm_partial();
      cur_min = 8'h35; cyc(3);
      check("R3 minutes differ", status, 0);
      cur_min = 8'h34; cur_hr = 8'h13; cyc(3);
      check("R3 hours differ", status, 0);
      cur_hr = 8'h12; cur_sec = 8'h57; cyc(3);
      check("R3 seconds differ", status, 0);
      en_alarm = 1'b0; cur_sec = 8'h56; cyc(3);
      check("R7 alarm disabled", status, 0);
   endtask

   task automatic t_periodic();
      en_periodic = 1'b1; rate_sel = 4'd3;
      pulse_tap(5);
      check("R4 other tap ignored", status, 0);
      taps[2] = 1'b1; cyc(1);
      check("R4 selected tap sets flag", status, 3'b010);
      taps[2] = 1'b0; read_clear();
      rate_sel = 4'd15;
      pulse_tap(13);
      check("R4 code 15 ignores tap 13", status, 0);
      taps[14] = 1'b1; cyc(1);
      check("R4 code 15 selects tap 14", status, 3'b010);
      taps[14] = 1'b0; read_clear();
      rate_sel = 4'd0;
      for (int k = 0; k < 15; k++) pulse_tap(k);
      check("R5 code 0 disables", status, 0);
      en_periodic = 1'b0; rate_sel = 4'd3;
      pulse_tap(2);
      check("R7 periodic disabled", status, 0);
      rate_sel = 4'd0;
   endtask

   task automatic t_pfail();
      pwr_fail = 1'b1; cyc(2);
      check("R7 power-fail disabled", status, 0);
      check("R7 irq stays released", irq_pulldown, 0);
      pwr_fail = 1'b0; en_pfail = 1'b1; cyc(1);
      pwr_fail = 1'b1; cyc(1);
      check("R6 power-fail flag", status, 3'b100);
      pwr_fail = 1'b0; cyc(1);
      read_clear();
      check("R9 cleared", status, 0);
      pwr_fail = 1'b1; stat_rd = 1'b1; cyc(1); stat_rd = 1'b0;
      check("R9 event beats read", status, 3'b100);
      pwr_fail = 1'b0; read_clear();
      en_pfail = 1'b0;
   endtask

   task automatic t_cpur_pf();
      pwr_fail = 1'b1; #1;
      check("R14 no reset when disabled", cpu_rst, 0);
      cyc(1); cpur_en = 1'b1; #1;
      check("R10 reset follows power-fail", cpu_rst, 1);
      cyc(1); pwr_fail = 1'b0; #1;
      check("R10 reset drops", cpu_rst, 0);
      cyc(1); cpur_en = 1'b0; cyc(1);
   endtask

   task automatic count_pulse(string req);
      int hi = 0;
      for (int k = 0; k < 12; k++) begin
         if (cpu_rst) hi++;
         cyc(1);
      end
      check(req, hi, 8);
   endtask

   task automatic t_wdog_expire();
      cpur_en = 1'b1; cyc(1);
      for (int k = 0; k < 3; k++) pulse_tap(7);
      check("R11 no reset before limit", cpu_rst, 0);
      taps[7] = 1'b1; cyc(1); taps[7] = 1'b0;
      check("R11 reset at limit", cpu_rst, 1);
      count_pulse("R11 pulse width");
      check("R11 pulse ended", cpu_rst, 0);
   endtask

   task automatic t_wdog_kick();
      for (int k = 0; k < 3; k++) pulse_tap(7);
      ce_pulse(1'b0);
      for (int k = 0; k < 3; k++) pulse_tap(7);
      check("R12 kick restarts count", cpu_rst, 0);
      pulse_tap(7);
      check("R12 expires after restart", cpu_rst, 1);
      cyc(12);
   endtask

   task automatic t_wdog_dirty();
      for (int k = 0; k < 3; k++) pulse_tap(7);
      ce_pulse(1'b1);
      check("R13 before tick", cpu_rst, 0);
      taps[7] = 1'b1; cyc(1); taps[7] = 1'b0;
      check("R13 transfer pulse no kick", cpu_rst, 1);
      cyc(12);
   endtask

   task automatic t_cpur_off();
      for (int k = 0; k < 3; k++) pulse_tap(7);
      cpur_en = 1'b0; cyc(1);
      cpur_en = 1'b1; cyc(1);
      for (int k = 0; k < 3; k++) pulse_tap(7);
      check("R14 disable clears count", cpu_rst, 0);
      cpur_en = 1'b0;
      for (int k = 0; k < 6; k++) pulse_tap(7);
      check("R14 disabled no reset", cpu_rst, 0);
   endtask

   initial begin
      cyc(3);
      t_reset();
      rst_n = 1'b1; cyc(1);
      t_reset();
      t_alarm();
      t_alarm_partial();
      t_periodic();
      t_pfail();
      t_cpur_pf();
      t_wdog_expire();
      t_wdog_kick();
      t_wdog_dirty();
      t_cpur_off();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule